// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block sits on a two-wire serial bus as a slave and gives the bus master read and write access to a small bank of 8-bit configuration registers. Each register bit goes straight out on a parallel bus to the logic it controls, for example one enable bit per clock output. Every register holds a fixed power-up value, so the controlled logic runs correctly even if the master never touches the bus.

Clock and data come in already synchronised to the block clock. The block watches both lines for start and stop conditions and for clock edges. It shifts each byte in or out most significant bit first, acknowledges its own address and each byte it takes in, and decodes a command byte. The top bit of the command byte selects how registers are reached. When it is set, the lower seven bits give one register offset. When it is clear, access runs in sequence upward from offset zero. The data line is never driven high: the block only pulls it low through an enable output.

To read, the master first writes the command byte, then sends a repeated start with the read address. The slave then returns register contents until the master declines to acknowledge.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register reads 0xFF on `cfg_o` (register k in bits 8k+7..8k) and `sda_pull_o` is low.
- R2: The slave acknowledges (pulls the data line low in the ninth clock slot) the address byte 0xDC for writes and 0xDD for reads.
- R3: After any other address byte the slave does not acknowledge, never pulls the data line, and changes no register until the next start condition.
- R4: A command byte with bit 7 = 1 sets the register pointer to command bits 6:0. A command byte with bit 7 = 0 sets the pointer to zero.
- R5: The slave acknowledges the command byte and every data byte written to it.
- R6: Bytes are shifted most significant bit first in both directions.
- R7: Each written data byte goes to the register at the pointer, and the pointer then advances by one, so a block write fills consecutive registers. The master may stop after any whole byte.
- R8: In a read, the slave drives the register at the pointer and then advances the pointer. It keeps sending while the master acknowledges, and it releases the line and sends nothing more once the master does not acknowledge.
- R9: A register changes only once all eight bits of its data byte have arrived. A byte cut short by a stop leaves the register unchanged.
- R10: A write to an offset at or above the register count is acknowledged but changes nothing. A read from such an offset returns 0x00.
- R11: A start condition is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. A repeated start restarts address decoding. After a stop, bus traffic without a new start is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the bus lines |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line, already synchronised |
| sda_i | input | 1 | Serial data line as seen on the wire, already synchronised |
| sda_pull_o | output | 1 | High pulls the data line low; low releases it |
| cfg_o | output | NUM_REGS*8 | All configuration registers, register k in bits 8k+7..8k |

## Verification
The assertions check, on every cycle, the rules that never depend on data values. The data line stays released while the slave is idle or ignoring the bus. Outside a read, the slave pulls the line only in an acknowledge slot. A start always returns decoding to the address byte with the bit count cleared, and a stop always returns the block to idle. A register changes only in the cycle after a full byte has been written to its offset. Only the bench scenarios can show the values that reach the wire and the registers: bit order, pointer selection and auto-increment, the contents of read data, out-of-range offsets, and the effect of truncated bytes and repeated starts.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    // Seven-bit device address; the wire byte is {DEV_ADDR, rw}
    localparam logic [6:0] DEV_ADDR = 7'h6E;
    localparam int         PTR_W    = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    // Line events, valid for one block-clock cycle
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    // Write request toward the register bank
    typedef struct packed {
        logic             we;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       wdata;
    } reg_wr_t;

    function automatic logic addr_hit(input logic [7:0] b);
        return b[7:1] == DEV_ADDR;
    endfunction

    // Indexed access when bit 7 set, sequential from zero otherwise
    function automatic logic [PTR_W-1:0] start_ptr(input logic [7:0] cmd);
        return cmd[7] ? cmd[6:0] : '0;
    endfunction

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events
    import smb_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);

    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.start = scl_q & scl & sda_q & ~sda;
        evt.stop  = scl_q & scl & ~sda_q & sda;
        evt.rise  = ~scl_q & scl;
        evt.fall  = scl_q & ~scl;
        evt.sda   = sda;
    end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS   = 8,
    parameter logic [7:0] RESET_BYTE = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_wr_t               wr,
    input  logic [PTR_W-1:0]      rd_ptr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam int               IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [PTR_W-1:0] NREG  = PTR_W'(NUM_REGS);

    logic [7:0] mem_q [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst)
                mem_q[i] <= RESET_BYTE;
            else if (wr.we && wr.ptr == PTR_W'(i))
                mem_q[i] <= wr.wdata;
        end
    end

    // Offsets outside the bank read as zero
    always_comb begin
        rd_data = '0;
        if (rd_ptr < NREG)
            rd_data = mem_q[rd_ptr[IDX_W-1:0]];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*8 +: 8] = mem_q[g];

        // R9
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr.we && wr.ptr == PTR_W'(g)) |=> $stable(mem_q[g]));
    end

endmodule

// File: rtl/smb_xfer_ctrl.sv
module smb_xfer_ctrl
    import smb_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_ptr,
    output reg_wr_t          wr,
    output logic             sda_oe
);

    phase_e           phase_q, nxt_q;
    logic [3:0]       bitcnt_q;
    logic             ack_slot_q, ack_pend_q, oe_q;
    logic [6:0]       rx_sr_q;
    logic [6:0]       tx_sr_q;
    logic [PTR_W-1:0] ptr_q;
    reg_wr_t          wr_q;
    logic [7:0]       rx_byte;

    assign rx_byte = {rx_sr_q, evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            nxt_q      <= PH_IDLE;
            bitcnt_q   <= '0;
            ack_slot_q <= 1'b0;
            ack_pend_q <= 1'b0;
            oe_q       <= 1'b0;
            rx_sr_q    <= '0;
            tx_sr_q    <= '0;
            ptr_q      <= '0;
            wr_q       <= '0;
        end else begin
            wr_q.we <= 1'b0;
            if (evt.stop) begin
                phase_q    <= PH_IDLE;
                oe_q       <= 1'b0;
                bitcnt_q   <= '0;
                ack_slot_q <= 1'b0;
            end else if (evt.start) begin
                phase_q    <= PH_ADDR;
                oe_q       <= 1'b0;
                bitcnt_q   <= '0;
                ack_slot_q <= 1'b0;
            end else if (phase_q == PH_IDLE || phase_q == PH_SKIP) begin
                oe_q <= 1'b0;
            end else if (evt.rise) begin
                if (ack_slot_q) begin
                    // Master acknowledge slot of a read: high means stop sending
                    if (phase_q == PH_RD && evt.sda)
                        nxt_q <= PH_SKIP;
                end else if (bitcnt_q != 4'd8) begin
                    rx_sr_q  <= rx_byte[6:0];
                    bitcnt_q <= bitcnt_q + 4'd1;
                    if (bitcnt_q == 4'd7) begin
                        case (phase_q)
                            PH_ADDR: begin
                                ack_pend_q <= addr_hit(rx_byte);
                                if (!addr_hit(rx_byte))
                                    nxt_q <= PH_SKIP;
                                else if (rx_byte[0])
                                    nxt_q <= PH_RD;
                                else
                                    nxt_q <= PH_CMD;
                            end
                            PH_CMD: begin
                                ack_pend_q <= 1'b1;
                                ptr_q      <= start_ptr(rx_byte);
                                nxt_q      <= PH_WR;
                            end
                            PH_WR: begin
                                ack_pend_q <= 1'b1;
                                wr_q       <= '{we: 1'b1, ptr: ptr_q, wdata: rx_byte};
                                ptr_q      <= ptr_q + 7'd1;
                                nxt_q      <= PH_WR;
                            end
                            default: begin
                                ack_pend_q <= 1'b0;
                                nxt_q      <= PH_RD;
                            end
                        endcase
                    end
                end
            end else if (evt.fall) begin
                if (ack_slot_q) begin
                    ack_slot_q <= 1'b0;
                    bitcnt_q   <= '0;
                    phase_q    <= nxt_q;
                    if (nxt_q == PH_RD) begin
                        tx_sr_q <= rd_data[6:0];
                        oe_q    <= ~rd_data[7];
                        ptr_q   <= ptr_q + 7'd1;
                    end else begin
                        oe_q <= 1'b0;
                    end
                end else if (bitcnt_q == 4'd8) begin
                    ack_slot_q <= 1'b1;
                    oe_q       <= ack_pend_q;
                end else if (phase_q == PH_RD && bitcnt_q != 4'd0) begin
                    tx_sr_q <= {tx_sr_q[5:0], 1'b0};
                    oe_q    <= ~tx_sr_q[6];
                end else begin
                    oe_q <= 1'b0;
                end
            end
        end
    end

    assign sda_oe = oe_q;
    assign wr     = wr_q;
    assign rd_ptr = ptr_q;

    // R3
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE || phase_q == PH_SKIP) |-> !oe_q);

    // R5
    pull_in_ack_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_q && phase_q != PH_RD) |-> ack_slot_q);

    // R11
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (phase_q == PH_IDLE && !oe_q));

    // R11
    start_to_addr_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (phase_q == PH_ADDR && bitcnt_q == 4'd0));

    // R9
    write_from_wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        wr_q.we |-> ($past(phase_q) == PH_WR && $past(evt.rise)));

    // R6
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        bitcnt_q <= 4'd8);

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS   = 8,
    parameter logic [7:0] RESET_BYTE = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    bus_evt_t         evt;
    reg_wr_t          wr;
    logic [PTR_W-1:0] rd_ptr;
    logic [7:0]       rd_data;

    smb_line_events u_events (
        .clk (clk),
        .rst (rst),
        .scl (scl_i),
        .sda (sda_i),
        .evt (evt)
    );

    smb_xfer_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_ptr  (rd_ptr),
        .wr      (wr),
        .sda_oe  (sda_pull_o)
    );

    smb_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .RESET_BYTE (RESET_BYTE)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data),
        .regs_o  (cfg_o)
    );

endmodule

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;

    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [NREG*8-1:0] cfg;
    wire  sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_fail = 0;
    int pull_cnt = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    always @(posedge clk) if (sda_pull) pull_cnt++;

    smb_cfg_slave #(.NUM_REGS(NREG), .RESET_BYTE(8'hFF)) dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .cfg_o      (cfg)
    );

    typedef struct packed {
        logic [6:0] off;
        logic [7:0] wd;
        logic [7:0] rd;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{7'd0,   8'h01, 8'h01},
        '{7'd3,   8'hA5, 8'hA5},
        '{7'd7,   8'h80, 8'h80},
        '{7'd5,   8'h3C, 8'h3C},
        '{7'd1,   8'h00, 8'h00},
        '{7'd9,   8'h77, 8'h00},
        '{7'd127, 8'h12, 8'h00}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] packed_model();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic hold();
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hold();
            scl_m = 1'b1; hold();
            scl_m = 1'b0; hold();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        acked = (sda_line == 1'b0);
        scl_m = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl_m = 1'b1; hold();
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        hold();
        sda_m = ~give_ack; hold();
        scl_m = 1'b1; hold();
        scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d, output int acks);
        logic a;
        acks = 0;
        bus_start();
        send_byte(8'hDC, a); acks += int'(a);
        send_byte({1'b1, off}, a); acks += int'(a);
        send_byte(d, a); acks += int'(a);
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d, output int acks);
        logic a;
        acks = 0;
        bus_start();
        send_byte(8'hDC, a); acks += int'(a);
        send_byte({1'b1, off}, a); acks += int'(a);
        bus_start();
        send_byte(8'hDD, a); acks += int'(a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int acks;
        logic a;
        logic [7:0] d;

        for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        hold();

        // R1 reset state
        chk(cfg == packed_model(), "R1 reset registers", cfg, packed_model());
        chk(sda_pull == 1'b0, "R1 reset line released", sda_pull, 0);

        // Vector table: byte write then byte read (R2 R4 R5 R6 R10)
        for (int v = 0; v < NVEC; v++) begin
            byte_write(VECS[v].off, VECS[v].wd, acks);
            chk(acks == 3, "R2/R5 byte write acks", acks, 3);
            if (VECS[v].off < NREG) model[VECS[v].off] = VECS[v].wd;
            chk(cfg == packed_model(), "R4/R6/R10 register port after write", cfg, packed_model());
            byte_read(VECS[v].off, d, acks);
            chk(acks == 3, "R2 byte read acks", acks, 3);
            chk(d == VECS[v].rd, "R6/R10 read data", d, VECS[v].rd);
        end

        // R7 block write from offset zero, command lower bits ignored
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h05, a);
        chk(a == 1'b1, "R5 block command ack", a, 1);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        chk(a == 1'b1, "R5 block data ack", a, 1);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        chk(cfg == packed_model(), "R7 block write consecutive", cfg, packed_model());

        // R8 block read of four bytes, nack on the last
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hDD, a);
        chk(a == 1'b1, "R2 read address ack", a, 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, d);
            chk(d == model[k], "R8 block read data", d, model[k]);
        end
        pull_cnt = 0;
        hold(); hold();
        chk(pull_cnt == 0, "R8 released after master nack", pull_cnt, 0);
        bus_stop();

        // R3 foreign address ignored
        pull_cnt = 0;
        bus_start();
        send_byte(8'hA4, a);
        chk(a == 1'b0, "R3 foreign address not acked", a, 0);
        send_byte(8'h80, a);
        send_byte(8'h55, a);
        bus_stop();
        chk(pull_cnt == 0, "R3 line never pulled", pull_cnt, 0);
        chk(cfg == packed_model(), "R3 registers unchanged", cfg, packed_model());

        // R9 truncated byte cut by stop
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h82, a);
        send_bits(8'h00, 5);
        bus_stop();
        chk(cfg == packed_model(), "R9 truncated byte ignored", cfg, packed_model());

        // R11 traffic after stop without start is ignored
        pull_cnt = 0;
        send_byte(8'hDC, a);
        send_byte(8'h83, a);
        send_byte(8'h00, a);
        chk(pull_cnt == 0, "R11 no response without start", pull_cnt, 0);
        chk(cfg == packed_model(), "R11 no write without start", cfg, packed_model());

        // R11 repeated start restarts address decoding
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h85, a);
        bus_start();
        send_byte(8'hDC, a);
        chk(a == 1'b1, "R11 address acked after repeated start", a, 1);
        send_byte(8'h86, a);
        send_byte(8'h5A, a);
        bus_stop();
        model[6] = 8'h5A;
        chk(cfg == packed_model(), "R11 repeated start write target", cfg, packed_model());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule